// File: doc/BRIEF.md
# Multicore Cluster Power Controller

This block sequences power for a small multicore system built from a parameterized number of clusters, each with a parameterized number of cores. The default is two clusters of four cores. Software talks to it through a simple register write/read port. Each command names a target core with a 24-bit affinity identifier, and the command's register offset selects the action. The actions are: power a core on, arm a deferred core power-down, arm a deferred cluster power-down, set or clear a core's wakeup enable, and choose which core the status register reports.

Power-down is never immediate. An armed core power-down completes when that core raises its standby-for-interrupt input. An armed cluster power-down completes when the cluster-level standby input is raised, and it then turns off the cluster and every core in it. A core that is off and has its wakeup enable set is powered back on by its wakeup interrupt. The block drives one power-enable per core and one per cluster. A status read returns the power state of the selected core, its pending flags and the reason it was last powered on.

Top module: `cluster_pwr_ctrl`

## Requirements
- R1: The affinity identifier is bits [23:0] of write data. Bits [15:8] give the cluster index, bits [7:0] give the core index within the cluster, and bits [23:16] must be zero. An identifier with a nonzero upper byte, a cluster index of NUM_CLUSTERS or more, or a core index of CORES_PER_CLUSTER or more is ignored by every command, including the status selector write. The flat core number is cluster*CORES_PER_CLUSTER+core.
- R2: After reset, exactly the cores set in STARTUP_MASK are powered. The default mask powers every core of cluster 0. A cluster is powered if any of its startup cores is. All pending flags and wakeup enables are 0, every reason field is 0, and the status selector points at core 0.0.
- R3: A write to offset 0x00 naming a powered core sets that core's pending-off flag and leaves it powered. The core's power-enable drops on the first clock edge at which its standby input is high while the flag is set, and the flag clears at the same edge. Standby inputs of other cores have no effect on it.
- R4: A write to offset 0x04 powers on the named core and its cluster. It clears the core's pending-off flag and the cluster's pending-off flag. If the core was off, its reason field becomes 1. This write wins over a standby input sampled at the same edge.
- R5: A write to offset 0x08 naming a core of a powered cluster sets that cluster's pending-off flag. When the cluster standby input is high while the flag is set, the cluster and all of its cores power off and all of their pending flags clear. The cluster standby input has no effect when the flag is clear.
- R6: A write to offset 0x0C sets the named core's wakeup enable to bit 31 of the write data.
- R7: A high wakeup interrupt for a core that is off with its wakeup enable set powers that core and its cluster on at the next edge, with reason 2. With the enable clear, the interrupt has no effect.
- R8: A write to offset 0x10 stores the identifier as the status selector. A read at 0x10 returns the following for the selected core: bit 31 = 0 (no third affinity level), bit 30 = cluster powered, bit 29 = core powered, bit 28 = wakeup enable, bit 27 = cluster pending-off, bit 26 = core pending-off, bits [25:24] = reason (0 reset, 1 power-on command, 2 wakeup), and bits [23:0] = the selector. Reads at any other offset return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bus_wr_i | input | 1 | Write strobe, one write per cycle |
| bus_addr_i | input | 5 | Byte address; bits [4:2] select the register |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data (combinational, for the current address) |
| core_wfi_i | input | NUM_CLUSTERS*CORES_PER_CLUSTER | Per-core standby-for-interrupt |
| cluster_wfi_i | input | NUM_CLUSTERS | Per-cluster standby |
| wake_irq_i | input | NUM_CLUSTERS*CORES_PER_CLUSTER | Per-core wakeup interrupt |
| core_pwr_en_o | output | NUM_CLUSTERS*CORES_PER_CLUSTER | Per-core power enable |
| cluster_pwr_en_o | output | NUM_CLUSTERS | Per-cluster power enable |

## Verification
The bench sweeps every core through off, on and wakeup commands and reads back all status words after each step.

It checks the following corner cases:
- Standby raised on the wrong core, or before a power-down is armed. A design that powered down eagerly would drop the enable here.
- A power-on command in the same cycle as standby. A design with the wrong priority would lose the core.
- A power-on command that cancels a pending cluster power-down. A design that kept the flag would shut the cluster at the next cluster standby.
- Identifiers outside the configured range. A design that truncated them would alias to a real core.
- A wakeup interrupt to a core with its enable clear, which must leave the core off.

// File: rtl/pwrc_pkg.sv
`timescale 1ns/1ps
package pwrc_pkg;

  typedef enum logic [2:0] {
    REG_CORE_OFF = 3'd0,
    REG_CORE_ON  = 3'd1,
    REG_CL_OFF   = 3'd2,
    REG_WAKE_EN  = 3'd3,
    REG_STATUS   = 3'd4
  } reg_sel_e;

  typedef enum logic [1:0] {
    RSN_RESET = 2'd0,
    RSN_CMD   = 2'd1,
    RSN_WAKE  = 2'd2,
    RSN_RSVD  = 2'd3
  } pwr_reason_e;

endpackage

// File: rtl/pwrc_aff_decode.sv
`timescale 1ns/1ps
module pwrc_aff_decode #(
  parameter int NUM_CLUSTERS      = 2,
  parameter int CORES_PER_CLUSTER = 4,
  parameter int IDX_W             = 3,
  parameter int CL_W              = 1
) (
  input  logic [23:0]      aff_i,
  output logic             hit_o,
  output logic [IDX_W-1:0] idx_o,
  output logic [CL_W-1:0]  cl_o
);

  logic upper_ok, cl_ok, core_ok;

  always_comb begin
    upper_ok = (aff_i[23:16] == 8'd0);
    cl_ok    = (aff_i[15:8] < 8'(NUM_CLUSTERS));
    core_ok  = (aff_i[7:0]  < 8'(CORES_PER_CLUSTER));
    hit_o    = upper_ok && cl_ok && core_ok;
    idx_o    = IDX_W'(aff_i[15:8]) * IDX_W'(CORES_PER_CLUSTER) + IDX_W'(aff_i[7:0]);
    cl_o     = CL_W'(aff_i[15:8]);
  end

endmodule

// File: rtl/pwrc_core_slice.sv
`timescale 1ns/1ps
module pwrc_core_slice
  import pwrc_pkg::*;
#(
  parameter bit START_ON = 1'b0
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        cmd_on_i,
  input  logic        cmd_off_i,
  input  logic        wen_wr_i,
  input  logic        wen_val_i,
  input  logic        wfi_i,
  input  logic        irq_i,
  input  logic        cl_down_i,
  output logic        on_o,
  output logic        pend_o,
  output logic        wen_o,
  output logic [1:0]  rsn_o,
  output logic        on_req_o
);

  logic        on_q, on_d;
  logic        pend_q, pend_d;
  logic        wen_q, wen_d;
  pwr_reason_e rsn_q, rsn_d;
  logic        wake_evt;

  assign wake_evt = !on_q && wen_q && irq_i;
  assign on_req_o = cmd_on_i || wake_evt;

  // next state
  always_comb begin
    on_d   = on_q;
    pend_d = pend_q;
    rsn_d  = rsn_q;
    wen_d  = wen_wr_i ? wen_val_i : wen_q;
    if (cmd_on_i) begin
      on_d   = 1'b1;
      pend_d = 1'b0;
      if (!on_q) rsn_d = RSN_CMD;
    end else if (cl_down_i) begin
      on_d   = 1'b0;
      pend_d = 1'b0;
    end else if (wake_evt) begin
      on_d   = 1'b1;
      rsn_d  = RSN_WAKE;
    end else if (on_q && pend_q && wfi_i) begin
      on_d   = 1'b0;
      pend_d = 1'b0;
    end else if (cmd_off_i && on_q) begin
      pend_d = 1'b1;
    end
  end

  // state registers
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      on_q   <= START_ON;
      pend_q <= 1'b0;
      wen_q  <= 1'b0;
      rsn_q  <= RSN_RESET;
    end else begin
      on_q   <= on_d;
      pend_q <= pend_d;
      wen_q  <= wen_d;
      rsn_q  <= rsn_d;
    end
  end

  assign on_o   = on_q;
  assign pend_o = pend_q;
  assign wen_o  = wen_q;
  assign rsn_o  = rsn_q;

  // R3
  pend_needs_on_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_q |-> on_q);

  // R3
  off_only_by_standby_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(on_q) |-> $past(wfi_i || cl_down_i));

  // R7
  wake_powers_on_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!on_q && wen_q && irq_i) |=> on_q);

  // R4
  cmd_on_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_on_i |=> (on_q && !pend_q));

endmodule

// File: rtl/pwrc_cluster_slice.sv
`timescale 1ns/1ps
module pwrc_cluster_slice #(
  parameter bit START_ON = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cmd_off_i,
  input  logic on_req_i,
  input  logic wfi_i,
  output logic on_o,
  output logic pend_o,
  output logic down_o
);

  logic on_q, on_d;
  logic pend_q, pend_d;

  assign down_o = pend_q && wfi_i && !on_req_i;

  // next state
  always_comb begin
    on_d   = on_q;
    pend_d = pend_q;
    if (on_req_i) begin
      on_d   = 1'b1;
      pend_d = 1'b0;
    end else if (down_o) begin
      on_d   = 1'b0;
      pend_d = 1'b0;
    end else if (cmd_off_i && on_q) begin
      pend_d = 1'b1;
    end
  end

  // state registers
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      on_q   <= START_ON;
      pend_q <= 1'b0;
    end else begin
      on_q   <= on_d;
      pend_q <= pend_d;
    end
  end

  assign on_o   = on_q;
  assign pend_o = pend_q;

  // R5
  cl_off_by_standby_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(on_q) |-> $past(wfi_i && pend_q));

  // R4
  cl_on_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    on_req_i |=> (on_q && !pend_q));

endmodule

// File: rtl/cluster_pwr_ctrl.sv
`timescale 1ns/1ps
module cluster_pwr_ctrl
  import pwrc_pkg::*;
#(
  parameter int NUM_CLUSTERS      = 2,
  parameter int CORES_PER_CLUSTER = 4,
  parameter logic [NUM_CLUSTERS*CORES_PER_CLUSTER-1:0] STARTUP_MASK =
    (NUM_CLUSTERS*CORES_PER_CLUSTER)'((1 << CORES_PER_CLUSTER) - 1)
) (
  input  logic                                        clk_i,
  input  logic                                        rst_ni,
  input  logic                                        bus_wr_i,
  input  logic [4:0]                                  bus_addr_i,
  input  logic [31:0]                                 bus_wdata_i,
  output logic [31:0]                                 bus_rdata_o,
  input  logic [NUM_CLUSTERS*CORES_PER_CLUSTER-1:0]   core_wfi_i,
  input  logic [NUM_CLUSTERS-1:0]                     cluster_wfi_i,
  input  logic [NUM_CLUSTERS*CORES_PER_CLUSTER-1:0]   wake_irq_i,
  output logic [NUM_CLUSTERS*CORES_PER_CLUSTER-1:0]   core_pwr_en_o,
  output logic [NUM_CLUSTERS-1:0]                     cluster_pwr_en_o
);

  localparam int NCORES = NUM_CLUSTERS * CORES_PER_CLUSTER;
  localparam int IDX_W  = (NCORES > 1) ? $clog2(NCORES) : 1;
  localparam int CL_W   = (NUM_CLUSTERS > 1) ? $clog2(NUM_CLUSTERS) : 1;

  reg_sel_e          reg_sel;
  logic              w_hit;
  logic [IDX_W-1:0]  w_idx;
  logic [CL_W-1:0]   w_cl;
  logic              s_hit;
  logic [IDX_W-1:0]  s_idx;
  logic [CL_W-1:0]   s_cl;
  logic [23:0]       sel_q, sel_d;

  logic [NCORES-1:0]            core_on, core_pend, core_wen, on_req;
  logic [NCORES-1:0][1:0]       core_rsn;
  logic [NUM_CLUSTERS-1:0]      cl_on, cl_pend, cl_down;

  logic unused_bits;
  assign unused_bits = ^{bus_addr_i[1:0], bus_wdata_i[30:24], s_hit};

  assign reg_sel = reg_sel_e'(bus_addr_i[4:2]);

  pwrc_aff_decode #(
    .NUM_CLUSTERS(NUM_CLUSTERS), .CORES_PER_CLUSTER(CORES_PER_CLUSTER),
    .IDX_W(IDX_W), .CL_W(CL_W)
  ) i_wr_dec (
    .aff_i(bus_wdata_i[23:0]), .hit_o(w_hit), .idx_o(w_idx), .cl_o(w_cl)
  );

  pwrc_aff_decode #(
    .NUM_CLUSTERS(NUM_CLUSTERS), .CORES_PER_CLUSTER(CORES_PER_CLUSTER),
    .IDX_W(IDX_W), .CL_W(CL_W)
  ) i_sel_dec (
    .aff_i(sel_q), .hit_o(s_hit), .idx_o(s_idx), .cl_o(s_cl)
  );

  // status selector
  always_comb begin
    sel_d = sel_q;
    if (bus_wr_i && reg_sel == REG_STATUS && w_hit) sel_d = bus_wdata_i[23:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sel_q <= 24'd0;
    else         sel_q <= sel_d;
  end

  // per-cluster and per-core slices
  for (genvar c = 0; c < NUM_CLUSTERS; c++) begin : g_cl
    logic cl_cmd_off;
    assign cl_cmd_off = bus_wr_i && reg_sel == REG_CL_OFF && w_hit && w_cl == CL_W'(c);

    pwrc_cluster_slice #(
      .START_ON(|STARTUP_MASK[c*CORES_PER_CLUSTER +: CORES_PER_CLUSTER])
    ) i_cl (
      .clk_i(clk_i), .rst_ni(rst_ni),
      .cmd_off_i(cl_cmd_off),
      .on_req_i(|on_req[c*CORES_PER_CLUSTER +: CORES_PER_CLUSTER]),
      .wfi_i(cluster_wfi_i[c]),
      .on_o(cl_on[c]), .pend_o(cl_pend[c]), .down_o(cl_down[c])
    );

    for (genvar k = 0; k < CORES_PER_CLUSTER; k++) begin : g_core
      localparam int I = c * CORES_PER_CLUSTER + k;
      logic tgt;
      assign tgt = bus_wr_i && w_hit && w_idx == IDX_W'(I);

      pwrc_core_slice #(.START_ON(STARTUP_MASK[I])) i_core (
        .clk_i(clk_i), .rst_ni(rst_ni),
        .cmd_on_i(tgt && reg_sel == REG_CORE_ON),
        .cmd_off_i(tgt && reg_sel == REG_CORE_OFF),
        .wen_wr_i(tgt && reg_sel == REG_WAKE_EN),
        .wen_val_i(bus_wdata_i[31]),
        .wfi_i(core_wfi_i[I]),
        .irq_i(wake_irq_i[I]),
        .cl_down_i(cl_down[c]),
        .on_o(core_on[I]), .pend_o(core_pend[I]), .wen_o(core_wen[I]),
        .rsn_o(core_rsn[I]), .on_req_o(on_req[I])
      );

      // R4
      core_in_live_cluster_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        core_on[I] |-> cl_on[c]);
    end
  end

  // read mux
  always_comb begin
    bus_rdata_o = 32'd0;
    if (reg_sel == REG_STATUS) begin
      bus_rdata_o = {1'b0, cl_on[s_cl], core_on[s_idx], core_wen[s_idx],
                     cl_pend[s_cl], core_pend[s_idx], core_rsn[s_idx], sel_q};
    end
  end

  assign core_pwr_en_o    = core_on;
  assign cluster_pwr_en_o = cl_on;

  // R5
  cl_down_clears_cores_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cl_on[0]) |-> (core_on[CORES_PER_CLUSTER-1:0] == '0));

endmodule

// File: tb/test_cluster_pwr_ctrl.sv
`timescale 1ns/1ps
module test_cluster_pwr_ctrl;

  localparam int NC = 2;
  localparam int CPC = 4;
  localparam int N = NC * CPC;

  logic clk = 1'b0;
  logic rst_n;
  logic bus_wr;
  logic [4:0] bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic [N-1:0] core_wfi, wake_irq, core_pwr_en;
  logic [NC-1:0] cluster_wfi, cluster_pwr_en;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  // bench model
  bit m_on[N], m_pend[N], m_wen[N];
  logic [1:0] m_rsn[N];
  bit m_clon[NC], m_pcl[NC];

  always #10 clk = ~clk;

  cluster_pwr_ctrl #(.NUM_CLUSTERS(NC), .CORES_PER_CLUSTER(CPC)) i_cluster_pwr_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .bus_wr_i(bus_wr), .bus_addr_i(bus_addr),
    .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata), .core_wfi_i(core_wfi),
    .cluster_wfi_i(cluster_wfi), .wake_irq_i(wake_irq),
    .core_pwr_en_o(core_pwr_en), .cluster_pwr_en_o(cluster_pwr_en)
  );

  function automatic logic [23:0] aff(int i);
    return {8'd0, 8'(i / CPC), 8'(i % CPC)};
  endfunction

  task automatic check(string req, int idx, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s idx=%0d act=%h exp=%h", req, idx, act, exp);
    end
  endtask

  task automatic wr(logic [4:0] a, logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0; bus_addr = 5'h10;
  endtask

  task automatic check_all(string req);
    logic [31:0] exp;
    logic [N-1:0] ep;
    logic [NC-1:0] ec;
    for (int i = 0; i < N; i++) begin
      wr(5'h10, {8'd0, aff(i)});
      exp = {1'b0, m_clon[i/CPC], m_on[i], m_wen[i], m_pcl[i/CPC], m_pend[i], m_rsn[i], aff(i)};
      #1 check({req, " R8 status"}, i, bus_rdata, exp);
      ep[i] = m_on[i];
    end
    for (int c = 0; c < NC; c++) ec[c] = m_clon[c];
    check({req, " core_pwr_en"}, -1, 32'(core_pwr_en), 32'(ep));
    check({req, " cluster_pwr_en"}, -1, 32'(cluster_pwr_en), 32'(ec));
  endtask

  task automatic m_on_cmd(int i);
    wr(5'h04, {8'd0, aff(i)});
    if (!m_on[i]) begin m_on[i] = 1; m_rsn[i] = 2'd1; end
    m_pend[i] = 0; m_clon[i/CPC] = 1; m_pcl[i/CPC] = 0;
  endtask

  task automatic m_off_cmd(int i);
    wr(5'h00, {8'd0, aff(i)});
    if (m_on[i]) m_pend[i] = 1;
  endtask

  task automatic m_cloff_cmd(int i);
    wr(5'h08, {8'd0, aff(i)});
    if (m_clon[i/CPC]) m_pcl[i/CPC] = 1;
  endtask

  task automatic m_wen_cmd(int i, bit v);
    wr(5'h0C, {v, 7'd0, aff(i)});
    m_wen[i] = v;
  endtask

  task automatic m_wfi(int i);
    @(negedge clk); core_wfi[i] = 1'b1;
    @(negedge clk); core_wfi[i] = 1'b0;
    if (m_on[i] && m_pend[i]) begin m_on[i] = 0; m_pend[i] = 0; end
  endtask

  task automatic m_clwfi(int c);
    @(negedge clk); cluster_wfi[c] = 1'b1;
    @(negedge clk); cluster_wfi[c] = 1'b0;
    if (m_pcl[c]) begin
      m_pcl[c] = 0; m_clon[c] = 0;
      for (int k = 0; k < CPC; k++) begin m_on[c*CPC+k] = 0; m_pend[c*CPC+k] = 0; end
    end
  endtask

  task automatic m_irq(int i);
    @(negedge clk); wake_irq[i] = 1'b1;
    @(negedge clk); wake_irq[i] = 1'b0;
    if (!m_on[i] && m_wen[i]) begin
      m_on[i] = 1; m_rsn[i] = 2'd2; m_clon[i/CPC] = 1; m_pcl[i/CPC] = 0;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog act=timeout exp=finished");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; bus_wr = 1'b0; bus_addr = 5'h10; bus_wdata = '0;
    core_wfi = '0; cluster_wfi = '0; wake_irq = '0;
    for (int i = 0; i < N; i++) begin
      m_on[i] = (i < CPC); m_pend[i] = 0; m_wen[i] = 0; m_rsn[i] = 2'd0;
    end
    m_clon[0] = 1; m_clon[1] = 0; m_pcl[0] = 0; m_pcl[1] = 0;
    repeat (3) @(negedge clk);
    #1 check("R2 reset core_pwr_en", -1, 32'(core_pwr_en), 32'h0F);
    check("R2 reset selector", -1, bus_rdata, {1'b0, 1'b1, 1'b1, 5'b0, 24'd0});
    @(negedge clk); rst_n = 1'b1;
    check_all("R2");

    // R3: deferred core power-down, other cores' standby ignored
    for (int i = 0; i < CPC; i++) begin
      m_off_cmd(i);
      check_all("R3 pending");
      m_wfi((i + 1) % N);
      m_wfi(i);
      check_all("R3 down");
    end

    // R4: power on every core
    for (int i = 0; i < N; i++) m_on_cmd(i);
    check_all("R4");

    // R6: wakeup enable write
    for (int i = 0; i < N; i++) m_wen_cmd(i, bit'(i % 2));
    check_all("R6");

    // R7: wakeup interrupts
    for (int i = CPC; i < N; i++) begin m_off_cmd(i); m_wfi(i); end
    check_all("R7 off");
    for (int i = CPC; i < N; i++) m_irq(i);
    check_all("R7 wake");
    m_wen_cmd(5, 1'b0);
    check_all("R6 clear");

    // R5: cluster power-down
    m_cloff_cmd(5);
    check_all("R5 pending");
    m_clwfi(0);
    m_clwfi(1);
    check_all("R5 down");

    // R4: power-on cancels pending cluster-off
    m_on_cmd(4);
    m_cloff_cmd(4);
    m_on_cmd(6);
    m_clwfi(1);
    check_all("R4 cancel");

    // R4: power-on and standby in the same cycle
    m_off_cmd(0);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = 5'h04; bus_wdata = {8'd0, aff(0)}; core_wfi[0] = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; bus_addr = 5'h10; core_wfi[0] = 1'b0;
    m_pend[0] = 0;
    check_all("R4 priority");

    // R1: out-of-range identifiers are ignored
    wr(5'h04, {8'd0, 8'd2, 8'd0});
    wr(5'h04, {8'd0, 8'd1, 8'd4});
    wr(5'h04, {8'd0, 8'd0, 8'd9});
    wr(5'h00, {8'd1, 8'd0, 8'd4});
    wr(5'h08, {8'd0, 8'd3, 8'd0});
    check_all("R1");

    // R1/R8: status selector keeps its value on an out-of-range write
    wr(5'h10, {8'd0, aff(3)});
    wr(5'h10, {8'd0, 8'd0, 8'd0, 8'd7});
    #1 check("R1 selector kept", 3, bus_rdata,
             {1'b0, m_clon[0], m_on[3], m_wen[3], m_pcl[0], m_pend[3], m_rsn[3], aff(3)});

    // R8: other offsets read as zero
    for (int a = 0; a < 8; a++) begin
      if (a != 4) begin
        bus_addr = 5'(a * 4);
        #1 check("R8 read zero", a, bus_rdata, 32'd0);
      end
    end
    bus_addr = 5'h10;

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule